// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block divides a slow count clock by ten and shows which of the ten counts is current. It holds its state in a five-stage twisted-ring shift register. Each of the ten legal ring patterns drives exactly one of ten one-hot outputs, and each output is formed from only two ring bits. A carry output is high for the first five counts and low for the last five, so it is a square wave at one tenth of the count rate.

Everything runs on one fast system clock. The count clock and the count-hold input arrive as levels that are already synchronous to that clock, and count events are found by comparing each level with its value one system cycle earlier. A count event is registered, so the ring moves on the second system edge after the edge that first samples the qualifying change. The ring has a correction term that clears isolated ones. Any pattern outside the ten-state cycle therefore drifts back into the cycle, and the correction never alters a legal step.

Top module: `johnson_decade`

## Requirements
- R1: With `rst` high at a system clock edge, from the next edge `dec_out` is 10'b0000000001 (count 0) and `carry_out` is 1. Reset is synchronous and active high.
- R2: When `count_hold` is 0 and `count_clk` changes from 0 to 1 between two system edges, the count rises by one. `dec_out` shows the new count two system edges after the first edge that samples `count_clk` high.
- R3: While `count_hold` is 1, no change of `count_clk` alters the count.
- R4: While `count_clk` is 1 and `rst` is 0, a 1-to-0 change of `count_hold` raises the count by one, with the same two-edge latency as R2.
- R5: A falling `count_clk`, a falling `count_hold` while `count_clk` is 0, and steady input levels leave the count unchanged.
- R6: For count n (0 to 9), `dec_out` has only bit n set. Count 9 is followed by count 0.
- R7: `carry_out` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R8: Reset wins over a qualifying edge seen in the same cycle. If `count_clk` is already high when reset is released, no count follows.
- R9: From every legal ring pattern, an advance gives the next legal pattern. The correction never changes a legal step.
- R10: A rise of `count_clk` in the same cycle as a fall of `count_hold` gives exactly one advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| count_clk | input | 1 | Sampled count clock level |
| count_hold | input | 1 | Sampled active-high count inhibit level |
| dec_out | output | 10 | One-hot decoded count, bit n for count n |
| carry_out | output | 1 | High during counts 0 to 4 |

## Verification
The embedded assertions check several rules on every cycle. A held inhibit never produces a count event. The ring stays frozen without an event and steps to a legal pattern from a legal one. Reset lands on the zero pattern. The decode stays one-hot, with carry agreeing with the lower five outputs. The bench scenarios show the edge rules, which the per-cycle checks cannot: which transitions of the two inputs count and which do not, the two-edge latency, the wrap from nine to zero, a simultaneous clock rise and inhibit fall counting only once, and reset winning against an edge in the same cycle, including release with the clock already high.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int STAGES  = 5;
  localparam int NCOUNTS = 2 * STAGES;

  typedef logic [STAGES-1:0] ring_t;

  // Twisted-ring step with the isolated-one eraser on stage 2.
  function automatic ring_t ring_step(ring_t r);
    ring_t n;
    n = {r[STAGES-2:0], ~r[STAGES-1]};
    if (r[1] && !r[0] && !r[2]) n[2] = 1'b0;
    return n;
  endfunction

  // A legal pattern has at most one boundary between adjacent stages.
  function automatic logic ring_ok(ring_t r);
    int t;
    t = 0;
    for (int i = 0; i < STAGES - 1; i++) t += (r[i] != r[i+1]) ? 1 : 0;
    return (t <= 1);
  endfunction
endpackage

// File: rtl/jdc_qualify.sv
module jdc_qualify (
  input  logic clk,
  input  logic rst,
  input  logic count_clk,
  input  logic count_hold,
  output logic adv
);
  logic clk_prev, hold_prev;
  logic clk_rise, hold_fall, evt;

  assign clk_rise  = count_clk & ~clk_prev & ~count_hold;
  assign hold_fall = ~count_hold & hold_prev & count_clk;
  assign evt       = clk_rise | hold_fall;

  always_ff @(posedge clk) begin
    clk_prev  <= count_clk;
    hold_prev <= count_hold;
    if (rst) adv <= 1'b0;
    else     adv <= evt;
  end

  // R3: inhibit held high never yields a count event
  p_hold_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    count_hold |=> !adv);
  // R5: a steady count clock with steady inhibit produces no event
  p_steady_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (count_clk == clk_prev && count_hold == hold_prev) |=> !adv);
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  output ring_t ring
);
  ring_t ring_nx;
  assign ring_nx = ring_step(ring);

  always_ff @(posedge clk) begin
    if (rst)      ring <= '0;
    else if (adv) ring <= ring_nx;
  end

  // R1: reset lands on the zero pattern
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> ring == '0);
  // R5: no event, no movement
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ring));
  // R9: a legal pattern steps to a legal, different pattern
  p_legal_step_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && ring_ok(ring)) |=> (ring_ok(ring) && ring != $past(ring)));
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ring_t              ring,
  output logic [NCOUNTS-1:0] dec,
  output logic               carry
);
  // Each output looks at two adjacent-stage bits only.
  assign dec[0]      = ~ring[STAGES-1] & ~ring[0];
  assign dec[STAGES] =  ring[STAGES-1] &  ring[0];
  for (genvar k = 1; k < STAGES; k++) begin : g_slot
    assign dec[k]          =  ring[k-1] & ~ring[k];
    assign dec[STAGES + k] = ~ring[k-1] &  ring[k];
  end
  assign carry = ~ring[STAGES-1];

  // R6: legal ring gives exactly one active output
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    ring_ok(ring) |-> $onehot(dec));
  // R7: carry agrees with the lower half of the decode
  p_carry_half_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot(dec) |-> (carry == |dec[STAGES-1:0]));
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade (
  input  logic       clk,
  input  logic       rst,
  input  logic       count_clk,
  input  logic       count_hold,
  output logic [9:0] dec_out,
  output logic       carry_out
);
  import jdc_pkg::*;

  logic  adv;
  ring_t ring;

  jdc_qualify u_qualify (
    .clk(clk), .rst(rst), .count_clk(count_clk),
    .count_hold(count_hold), .adv(adv)
  );

  jdc_ring u_ring (.clk(clk), .rst(rst), .adv(adv), .ring(ring));

  jdc_decode u_decode (
    .clk(clk), .rst(rst), .ring(ring), .dec(dec_out), .carry(carry_out)
  );

  // R8: a reset cycle is never followed by an advance
  p_reset_wins_r8: assert property (@(posedge clk) rst |=> !adv);
endmodule

// File: tb/johnson_decade_bench.sv
`timescale 1ns/1ps
module johnson_decade_bench;
  logic clk = 1'b0;
  logic rst, count_clk, count_hold;
  logic [9:0] dec_out;
  logic carry_out;

  int checks = 0;
  int errors = 0;
  int st = 0;
  logic [10:0] sb_val[$];
  string       sb_tag[$];
  bit          done = 0;

  always #2 clk = ~clk;

  johnson_decade u_johnson_decade (
    .clk(clk), .rst(rst), .count_clk(count_clk), .count_hold(count_hold),
    .dec_out(dec_out), .carry_out(carry_out)
  );

  task automatic drive(input logic c, input logic h, input logic r);
    @(negedge clk);
    count_clk = c; count_hold = h; rst = r;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input string tag);
    logic [9:0] q;
    q = 10'd1 << st;
    sb_val.push_back({(st < 5) ? 1'b1 : 1'b0, q});
    sb_tag.push_back(tag);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_val.size() > 0) begin
      logic [10:0] e;
      string t;
      e = sb_val.pop_front();
      t = sb_tag.pop_front();
      checks++;
      if ({carry_out, dec_out} !== e) begin
        errors++;
        $display("FAIL %s: got carry=%b dec=%b, expected carry=%b dec=%b",
                 t, carry_out, dec_out, e[10], e[9:0]);
      end
    end
  end

  task automatic pulse(input string tag);
    drive(1'b1, 1'b0, 1'b0); edges(2);
    st = (st + 1) % 10; expect_state(tag);
    drive(1'b0, 1'b0, 1'b0); edges(2);
    expect_state("R5 falling clock");
  endtask

  initial begin
    count_clk = 0; count_hold = 0; rst = 1;
    edges(2); st = 0; expect_state("R1 reset state");
    drive(1'b0, 1'b0, 1'b0); edges(2); expect_state("R1 after release");

    // R2, R6, R7: walk through and past the wrap
    for (int i = 0; i < 12; i++) pulse("R2/R6/R7 count step");

    // R3: inhibit blocks clock edges
    drive(1'b0, 1'b1, 1'b0); edges(2); expect_state("R3 hold raised");
    drive(1'b1, 1'b1, 1'b0); edges(2); expect_state("R3 rise under hold");
    drive(1'b0, 1'b1, 1'b0); edges(2); expect_state("R3 fall under hold");
    // R5: hold released with clock low does nothing
    drive(1'b0, 1'b0, 1'b0); edges(2); expect_state("R5 hold fall clock low");
    // R4: hold released with clock high advances
    drive(1'b0, 1'b1, 1'b0); edges(2);
    drive(1'b1, 1'b1, 1'b0); edges(2); expect_state("R3 rise under hold 2");
    drive(1'b1, 1'b0, 1'b0); edges(2);
    st = (st + 1) % 10; expect_state("R4 hold fall clock high");
    edges(3); expect_state("R4 single advance");

    // R10: simultaneous clock rise and hold fall
    drive(1'b0, 1'b1, 1'b0); edges(2);
    drive(1'b1, 1'b0, 1'b0); edges(2);
    st = (st + 1) % 10; expect_state("R10 combined edge");
    edges(4); expect_state("R10 no second count");

    // R8: reset with a simultaneous edge, release with clock high
    drive(1'b0, 1'b0, 1'b0); edges(2);
    drive(1'b1, 1'b0, 1'b1); edges(2);
    st = 0; expect_state("R8 reset over edge");
    drive(1'b1, 1'b0, 1'b0); edges(3); expect_state("R8 release clock high");
    edges(20); expect_state("R5 long steady");

    // R9: a full long run stays on the legal cycle
    drive(1'b0, 1'b0, 1'b0); edges(2);
    for (int i = 0; i < 23; i++) pulse("R9 legal sequence");

    edges(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule